// File: doc/BRIEF.md
# Keyed Configuration Port with Banked Device Registers

This block is the configuration front end of a multi-function peripheral chip. A host reaches it through two adjacent byte addresses on a byte-wide I/O bus: a pointer port that selects a register and a value port that reads or writes it. Configuration access stays closed after reset. The host opens it by writing an unlock key byte to the pointer port twice in a row, and closes it with a lock key byte.

While access is open, a device-select register picks which bank of per-device registers the value port reaches. Only one bank exists here: the infrared receiver function. It holds an enable bit, a 16-bit I/O base address and an interrupt line number. A few global registers sit outside the banks: the device select, a 16-bit chip identifier, a 16-bit maker identifier and a port-select byte. The enable, base address and interrupt line drive output pins for the downstream function logic.

Any byte address the block does not decode reads as 0xFF. The same holds for its own ports while access is closed. A host can therefore probe an alternate port pair and tell an absent chip from a present one.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset, access is closed, dev_en is 0, dev_base is 0x0000, dev_irq is 0, the device select is 0 and the pointer is 0.
- R2: Two consecutive writes of the unlock key (default 0x87) to the pointer port (default address 0x004E) open access. One unlock-key write alone leaves access closed.
- R3: A pointer-port write of any other value between the two unlock-key writes restarts the sequence, so a further two unlock-key writes are then needed.
- R4: While access is open, a pointer-port write of the lock key (default 0xAA) closes access. The lock key is not loaded as a pointer value.
- R5: While access is closed, value-port writes change nothing, and reads of both the pointer port and the value port (pointer address + 1) return 0xFF.
- R6: While access is open, a pointer-port write loads the pointer, which reads back from the pointer port. The value port then reads or writes the pointed register. Register 0x07 is the device select, readable and writable.
- R7: Global registers are read-only: 0x20/0x21 give the chip identifier high/low byte, 0x23/0x24 give the maker identifier high/low byte, and 0x27 gives the low byte of the pointer port address.
- R8: Pointer values 0x30 and above reach the device bank only when the device select equals the receiver device number (default 5). Otherwise writes there are ignored and reads return 0xFF.
- R9: In the receiver bank, 0x30 bit 0 is the enable, 0x60/0x61 are the base address high/low byte and 0x70 is the interrupt line. A write reaches dev_en, dev_base or dev_irq on the clock edge that takes it, and the register reads back its value.
- R10: Reads of any byte address other than the port pair return 0xFF, and writes there have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Host I/O byte address |
| io_wr | input | 1 | Host write strobe, one cycle per byte |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data, combinational from address and state |
| dev_en | output | 1 | Receiver function enable |
| dev_base | output | 16 | Receiver function I/O base address |
| dev_irq | output | 8 | Receiver function interrupt line |

## Verification
The unlock logic is tried with several pointer-port sequences. A lone key write, a key broken by a stray byte, and a restarted pair that succeeds separate a correct two-in-a-row detector from one that counts keys or ignores interruptions. Register traffic is sent once with the receiver device selected and once with another device selected. This shows whether banking gates both reads and writes. Value-port writes made while access is closed, and writes to a foreign address, are followed by read-back and output checks. These show that neither reaches any state.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
    typedef enum logic [1:0] {
        LK_CLOSED = 2'd0,
        LK_HALF   = 2'd1,
        LK_OPEN   = 2'd2
    } lock_e;

    localparam logic [7:0] RG_DEVSEL   = 8'h07;
    localparam logic [7:0] RG_CHIP_HI  = 8'h20;
    localparam logic [7:0] RG_CHIP_LO  = 8'h21;
    localparam logic [7:0] RG_MAKER_HI = 8'h23;
    localparam logic [7:0] RG_MAKER_LO = 8'h24;
    localparam logic [7:0] RG_PORTSEL  = 8'h27;
    localparam logic [7:0] RG_BANK_LO  = 8'h30;
    localparam logic [7:0] RG_EN       = 8'h30;
    localparam logic [7:0] RG_BASE_HI  = 8'h60;
    localparam logic [7:0] RG_BASE_LO  = 8'h61;
    localparam logic [7:0] RG_IRQ      = 8'h70;

    typedef struct packed {
        logic [7:0] ptr;
        logic [7:0] devsel;
    } glob_s;

    typedef struct packed {
        logic        en;
        logic [15:0] base;
        logic [7:0]  irq;
    } bank_s;
endpackage

// File: rtl/sio_key_unlock.sv
module sio_key_unlock
    import sio_cfg_pkg::*;
#(
    parameter logic [7:0] KEY_ON  = 8'h87,
    parameter logic [7:0] KEY_OFF = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ptr_wr,
    input  logic [7:0] wdata,
    output logic       unlocked
);
    lock_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ptr_wr) begin
            case (st_q)
                LK_CLOSED: st_d = (wdata == KEY_ON) ? LK_HALF : LK_CLOSED;
                LK_HALF:   st_d = (wdata == KEY_ON) ? LK_OPEN : LK_CLOSED;
                LK_OPEN:   st_d = (wdata == KEY_OFF) ? LK_CLOSED : LK_OPEN;
                default:   st_d = LK_CLOSED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LK_CLOSED;
        else        st_q <= st_d;
    end

    assign unlocked = (st_q == LK_OPEN);

    // R2: opening needs a key write in the cycle before it
    a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(ptr_wr && wdata == KEY_ON));

    // R4: lock key closes access
    a_r4_lock_key: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && ptr_wr && wdata == KEY_OFF) |=> !unlocked);

    // R3: a stray byte while half-way never opens access next cycle
    a_r3_stray_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && ptr_wr && wdata != KEY_ON) |=> !unlocked);
endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
    import sio_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  reg_sel,
    input  logic [7:0]  wdata,
    output logic        dev_en,
    output logic [15:0] dev_base,
    output logic [7:0]  dev_irq,
    output logic [7:0]  rd_data
);
    bank_s bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (wr_en) begin
            case (reg_sel)
                RG_EN:      bk_d.en         = wdata[0];
                RG_BASE_HI: bk_d.base[15:8] = wdata;
                RG_BASE_LO: bk_d.base[7:0]  = wdata;
                RG_IRQ:     bk_d.irq        = wdata;
                default:    ;
            endcase
        end
    end

    always_comb begin
        case (reg_sel)
            RG_EN:      rd_data = {7'd0, bk_q.en};
            RG_BASE_HI: rd_data = bk_q.base[15:8];
            RG_BASE_LO: rd_data = bk_q.base[7:0];
            RG_IRQ:     rd_data = bk_q.irq;
            default:    rd_data = 8'hFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign dev_en   = bk_q.en;
    assign dev_base = bk_q.base;
    assign dev_irq  = bk_q.irq;

    // R9: a base low write reaches the output on the next edge
    a_r9_base_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == RG_BASE_LO) |=> dev_base[7:0] == $past(wdata));

    // R5: without a write strobe the bank holds
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(dev_base) && $stable(dev_irq) && $stable(dev_en)));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter logic [15:0] PTR_ADDR  = 16'h004E,
    parameter logic [7:0]  KEY_ON    = 8'h87,
    parameter logic [7:0]  KEY_OFF   = 8'hAA,
    parameter logic [15:0] CHIP_ID   = 16'h0A51,
    parameter logic [15:0] MAKER_ID  = 16'h3C19,
    parameter logic [7:0]  RCV_DEVNO = 8'h05
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    output logic        dev_en,
    output logic [15:0] dev_base,
    output logic [7:0]  dev_irq
);
    localparam logic [15:0] VAL_ADDR = PTR_ADDR + 16'd1;

    logic       at_ptr, at_val, ptr_wr, val_wr, unlocked, in_bank, bank_sel, bank_wr;
    logic [7:0] bank_rd;
    glob_s      g_d, g_q;

    assign at_ptr   = (io_addr == PTR_ADDR);
    assign at_val   = (io_addr == VAL_ADDR);
    assign ptr_wr   = io_wr && at_ptr;
    assign val_wr   = io_wr && at_val && unlocked;
    assign in_bank  = (g_q.ptr >= RG_BANK_LO);
    assign bank_sel = in_bank && (g_q.devsel == RCV_DEVNO);
    assign bank_wr  = val_wr && bank_sel;

    sio_key_unlock #(.KEY_ON(KEY_ON), .KEY_OFF(KEY_OFF)) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_wr   (ptr_wr),
        .wdata    (io_wdata),
        .unlocked (unlocked)
    );

    sio_dev_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bank_wr),
        .reg_sel  (g_q.ptr),
        .wdata    (io_wdata),
        .dev_en   (dev_en),
        .dev_base (dev_base),
        .dev_irq  (dev_irq),
        .rd_data  (bank_rd)
    );

    always_comb begin
        g_d = g_q;
        if (ptr_wr && unlocked && io_wdata != KEY_OFF) g_d.ptr = io_wdata;
        if (val_wr && g_q.ptr == RG_DEVSEL)           g_d.devsel = io_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    always_comb begin
        io_rdata = 8'hFF;
        if (unlocked && at_ptr) begin
            io_rdata = g_q.ptr;
        end else if (unlocked && at_val) begin
            if (in_bank) begin
                io_rdata = bank_sel ? bank_rd : 8'hFF;
            end else begin
                case (g_q.ptr)
                    RG_DEVSEL:   io_rdata = g_q.devsel;
                    RG_CHIP_HI:  io_rdata = CHIP_ID[15:8];
                    RG_CHIP_LO:  io_rdata = CHIP_ID[7:0];
                    RG_MAKER_HI: io_rdata = MAKER_ID[15:8];
                    RG_MAKER_LO: io_rdata = MAKER_ID[7:0];
                    RG_PORTSEL:  io_rdata = PTR_ADDR[7:0];
                    default:     io_rdata = 8'hFF;
                endcase
            end
        end
    end

    // R5: closed access reads back as all ones at both ports
    a_r5_closed_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !unlocked && (at_ptr || at_val)) |-> io_rdata == 8'hFF);

    // R10: foreign addresses read as all ones
    a_r10_foreign_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !at_ptr && !at_val) |-> io_rdata == 8'hFF);

    // R8: with another device selected the receiver outputs hold
    a_r8_other_dev_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.devsel != RCV_DEVNO) |=> ($stable(dev_base) && $stable(dev_irq) && $stable(dev_en)));

    // R4: lock key never lands in the pointer
    a_r4_ptr_not_key: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr && io_wdata == KEY_OFF) |=> $stable(g_q.ptr));
endmodule

// File: tb/tb_sio_cfg_port.sv
`timescale 1ns/1ps
module tb_sio_cfg_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        dev_en;
    logic [15:0] dev_base;
    logic [7:0]  dev_irq;

    localparam logic [15:0] PA = 16'h004E;
    localparam logic [15:0] VA = 16'h004F;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    sio_cfg_port dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_en(dev_en),
        .dev_base(dev_base), .dev_irq(dev_irq)
    );

    // monitor: pops one expected byte per read strobe
    always @(posedge clk) begin
        if (io_rd) begin
            #1.0;
            if (exp_q.size() != 0) begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (io_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: read got %02h expected %02h", t, io_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] r, input logic [7:0] d);
        wr(PA, r); wr(VA, d);
    endtask

    task automatic reg_rd(input logic [7:0] r, input logic [7:0] e, input string t);
        wr(PA, r); rd(VA, e, t);
    endtask

    task automatic chk_out(input logic en, input logic [15:0] b, input logic [7:0] q, input string t);
        @(negedge clk);
        checks++;
        if (dev_en !== en || dev_base !== b || dev_irq !== q) begin
            errors++;
            $display("FAIL %s: outputs got en=%0b base=%04h irq=%02h expected en=%0b base=%04h irq=%02h",
                     t, dev_en, dev_base, dev_irq, en, b, q);
        end
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_out(1'b0, 16'h0000, 8'h00, "R1 reset outputs");
        rd(PA, 8'hFF, "R1/R5 closed after reset, pointer port");
        // R2 single key does not open
        wr(PA, 8'h87);
        rd(VA, 8'hFF, "R2 one key leaves access closed");
        // R3 stray byte restarts the sequence
        wr(PA, 8'h12);
        wr(PA, 8'h87);
        rd(PA, 8'hFF, "R3 stray byte restarted unlock");
        wr(PA, 8'h87);
        rd(PA, 8'h00, "R2 two keys open, pointer at reset value");
        // R6/R7 globals
        reg_rd(8'h20, 8'h0A, "R7 chip id high");
        reg_rd(8'h21, 8'h51, "R7 chip id low");
        reg_rd(8'h23, 8'h3C, "R7 maker id high");
        reg_rd(8'h24, 8'h19, "R7 maker id low");
        reg_rd(8'h27, 8'h4E, "R7 port select");
        reg_rd(8'h07, 8'h00, "R6 device select reset");
        rd(PA, 8'h07, "R6 pointer read back");
        // R8 wrong device: bank gated
        reg_wr(8'h07, 8'h03);
        reg_rd(8'h07, 8'h03, "R6 device select written");
        reg_wr(8'h60, 8'h55);
        reg_rd(8'h60, 8'hFF, "R8 other device reads FF");
        chk_out(1'b0, 16'h0000, 8'h00, "R8 other device write ignored");
        // R9 receiver bank
        reg_wr(8'h07, 8'h05);
        reg_wr(8'h60, 8'h03);
        reg_wr(8'h61, 8'hE8);
        reg_wr(8'h70, 8'h0B);
        reg_wr(8'h30, 8'h01);
        chk_out(1'b1, 16'h03E8, 8'h0B, "R9 bank outputs");
        reg_rd(8'h61, 8'hE8, "R9 base low read back");
        reg_rd(8'h30, 8'h01, "R9 enable read back");
        reg_rd(8'h70, 8'h0B, "R9 irq read back");
        // R10 foreign address
        wr(16'h0080, 8'h00);
        rd(16'h0080, 8'hFF, "R10 foreign read");
        rd(16'h002E, 8'hFF, "R10 alternate pair absent");
        reg_rd(8'h70, 8'h0B, "R10 foreign write left irq");
        chk_out(1'b1, 16'h03E8, 8'h0B, "R10 outputs unchanged");
        // R4 lock, pointer kept at 0x70
        wr(PA, 8'hAA);
        rd(PA, 8'hFF, "R4 lock key closes");
        // R5 closed write ignored
        wr(VA, 8'h99);
        rd(VA, 8'hFF, "R5 closed value port read");
        chk_out(1'b1, 16'h03E8, 8'h0B, "R5 closed write ignored");
        wr(PA, 8'h87); wr(PA, 8'h87);
        rd(PA, 8'h70, "R4 pointer kept over lock and key writes");
        rd(VA, 8'h0B, "R5 irq unchanged after closed write");
        // R1 reset again mid-use
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        chk_out(1'b0, 16'h0000, 8'h00, "R1 reset clears bank");
        rd(VA, 8'hFF, "R1 reset closes access");
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule